// File: doc/BRIEF.md
# Processor Status Word Register

This block is the eight-bit status word of a small microcontroller core. Its low nibble holds the four arithmetic flags (carry, half carry, zero, overflow), which the ALU updates one flag at a time and which software may also overwrite. Two further bits record system events: a sleep flag that marks entry into the power-down state, and a timeout flag that marks a watchdog expiry.

Software has no write path into the two system flags. They change only on power-up reset, on a watchdog expiry pulse, and on the decode strobes of the watchdog-clear and halt instructions. The register value is presented combinationally for reads. The core reset input is asynchronous and active low; its release is synchronised to the clock inside the block.

Top module: `psw_status`

## Requirements
- R1: The read value places carry at bit 0, half carry at bit 1, zero at bit 2, overflow at bit 3, sleep at bit 4 and timeout at bit 5; bits 6 and 7 always read 0.
- R2: Asserting rst_n low clears all six flags at once, without waiting for a clock edge, and they stay 0 until a flag event occurs after release.
- R3: A software write (sw_we high) loads sw_wdata[3:0] into bits 3:0 at the next rising clock edge.
- R4: A software write never changes the sleep or timeout flag.
- R5: alu_we bit i (bit 0 carry, 1 half carry, 2 zero, 3 overflow) loads alu_val bit i into that flag at the next edge and leaves every other flag unchanged.
- R6: When a software write and ALU strobes coincide, each strobed flag takes the ALU value and each unstrobed arithmetic flag takes the software value.
- R7: A halt strobe sets the sleep flag and clears the timeout flag.
- R8: A watchdog-clear strobe clears both the sleep and the timeout flag.
- R9: A watchdog expiry pulse sets the timeout flag and leaves the sleep flag unchanged.
- R10: A watchdog expiry in the same cycle as a halt or watchdog-clear strobe leaves the timeout flag set; the sleep flag still follows the instruction.
- R11: In a cycle with no strobe of any kind the value is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| alu_we | input | 4 | Per-flag update strobes from the ALU |
| alu_val | input | 4 | New flag values from the ALU |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 4 | Software write data for the arithmetic flags |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| clr_wdt | input | 1 | Watchdog-clear instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| status_rd | output | 8 | Status word read value |

## Verification
Software writes of all-ones and all-zeros tell apart the arithmetic bits, which must follow the data, from the system bits, which must not, and are repeated while the timeout and sleep flags are set. Single-flag ALU strobes show that one flag moves alone, and a strobe mask mixed with a software write shows which source each flag takes. Each system event is applied alone and then paired with a watchdog expiry, so the priority of the expiry on the timeout flag is separated from the instruction's effect on the sleep flag.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W    = 8;
  localparam int ALU_FLAGS = 4;
  localparam int BIT_C     = 0;
  localparam int BIT_AC    = 1;
  localparam int BIT_Z     = 2;
  localparam int BIT_OV    = 3;
  localparam int BIT_PDF   = 4;
  localparam int BIT_TO    = 5;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] alu_we,
  input  logic [NF-1:0] alu_val,
  input  logic          sw_we,
  input  logic [NF-1:0] sw_val,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] flag_en;
  logic [NF-1:0] flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    // ALU strobe outranks the software write for its own flag
    always_comb begin
      flag_en[i] = alu_we[i] | sw_we;
      flag_d[i]  = alu_we[i] ? alu_val[i] : sw_val[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (flag_en[i]) flags_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/psw_sys_flags.sv
module psw_sys_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_expire,
  input  logic clr_wdt,
  input  logic halt,
  output logic pdf_q,
  output logic to_q
);
  logic pdf_en, pdf_d;
  logic to_en,  to_d;

  always_comb begin
    // sleep flag: halt sets, watchdog clear resets
    pdf_en = clr_wdt | halt;
    pdf_d  = halt;
    // timeout flag: expiry sets and outranks both instructions
    to_en  = wdt_expire | clr_wdt | halt;
    to_d   = wdt_expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pdf_q <= 1'b0;
    else if (pdf_en) pdf_q <= pdf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     to_q <= 1'b0;
    else if (to_en) to_q <= to_d;
  end
endmodule

// File: rtl/psw_status.sv
module psw_status
  import psw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ALU_FLAGS-1:0] alu_we,
  input  logic [ALU_FLAGS-1:0] alu_val,
  input  logic                 sw_we,
  input  logic [ALU_FLAGS-1:0] sw_wdata,
  input  logic                 wdt_expire,
  input  logic                 clr_wdt,
  input  logic                 halt,
  output logic [WORD_W-1:0]    status_rd
);
  logic                 rst_sync_n;
  logic [ALU_FLAGS-1:0] arith_q;
  logic                 pdf_q;
  logic                 to_q;

  psw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  psw_alu_flags #(.NF(ALU_FLAGS)) u_arith (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .alu_we  (alu_we),
    .alu_val (alu_val),
    .sw_we   (sw_we),
    .sw_val  (sw_wdata),
    .flags_q (arith_q)
  );

  psw_sys_flags u_sys (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wdt_expire (wdt_expire),
    .clr_wdt    (clr_wdt),
    .halt       (halt),
    .pdf_q      (pdf_q),
    .to_q       (to_q)
  );

  always_comb begin
    status_rd          = '0;
    status_rd[BIT_C]   = arith_q[0];
    status_rd[BIT_AC]  = arith_q[1];
    status_rd[BIT_Z]   = arith_q[2];
    status_rd[BIT_OV]  = arith_q[3];
    status_rd[BIT_PDF] = pdf_q;
    status_rd[BIT_TO]  = to_q;
  end
endmodule

// File: rtl/psw_status_chk.sv
module psw_status_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [3:0] alu_we,
  input logic [3:0] alu_val,
  input logic       sw_we,
  input logic [3:0] sw_wdata,
  input logic       wdt_expire,
  input logic       clr_wdt,
  input logic       halt,
  input logic [7:0] status_rd
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!srst_n)
    status_rd[7:6] == 2'b00);

  a_r4_sw_keeps_sys: assert property (@(posedge clk) disable iff (!srst_n)
    (sw_we && !wdt_expire && !clr_wdt && !halt) |=> status_rd[5:4] == $past(status_rd[5:4]));

  a_r3_sw_loads: assert property (@(posedge clk) disable iff (!srst_n)
    (sw_we && alu_we == 4'b0000) |=> status_rd[3:0] == $past(sw_wdata));

  a_r5_alu_carry: assert property (@(posedge clk) disable iff (!srst_n)
    alu_we[0] |=> status_rd[0] == $past(alu_val[0]));

  a_r7_halt_sleep: assert property (@(posedge clk) disable iff (!srst_n)
    halt |=> status_rd[4]);

  a_r8_clr_wake: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_wdt && !halt) |=> !status_rd[4]);

  a_r10_expire_sets: assert property (@(posedge clk) disable iff (!srst_n)
    wdt_expire |=> status_rd[5]);

  a_r11_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!sw_we && alu_we == 4'b0000 && !wdt_expire && !clr_wdt && !halt) |=> $stable(status_rd));
endmodule

bind psw_status psw_status_chk u_chk (
  .clk        (clk),
  .srst_n     (rst_sync_n),
  .alu_we     (alu_we),
  .alu_val    (alu_val),
  .sw_we      (sw_we),
  .sw_wdata   (sw_wdata),
  .wdt_expire (wdt_expire),
  .clr_wdt    (clr_wdt),
  .halt       (halt),
  .status_rd  (status_rd)
);

// File: tb/psw_status_test.sv
module psw_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] alu_we;
  logic [3:0] alu_val;
  logic       sw_we;
  logic [3:0] sw_wdata;
  logic       wdt_expire;
  logic       clr_wdt;
  logic       halt;
  logic [7:0] status_rd;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  psw_status uut (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .wdt_expire(wdt_expire),
    .clr_wdt(clr_wdt), .halt(halt), .status_rd(status_rd)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_cmp++;
    if (status_rd !== exp) begin
      n_bad++;
      $display("FAIL %s: status actual %02h expected %02h", req, status_rd, exp);
    end
  endtask

  task automatic idle_inputs();
    alu_we = '0; alu_val = '0; sw_we = 1'b0; sw_wdata = '0;
    wdt_expire = 1'b0; clr_wdt = 1'b0; halt = 1'b0;
  endtask

  // drive one cycle of stimulus at a falling edge, remove it at the next
  task automatic pulse(input logic [3:0] awe, input logic [3:0] aval,
                       input logic swe, input logic [3:0] swd,
                       input logic wdt, input logic clr, input logic hlt);
    @(negedge clk);
    alu_we = awe; alu_val = aval; sw_we = swe; sw_wdata = swd;
    wdt_expire = wdt; clr_wdt = clr; halt = hlt;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R2 reset clears", 8'h00);
  endtask

  task automatic t_sw_write();
    pulse(4'h0, 4'h0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0);
    check("R3/R1 write all ones", 8'h0F);
    pulse(4'h0, 4'h0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
    check("R3 write zeros", 8'h00);
  endtask

  task automatic t_alu();
    pulse(4'b0100, 4'b0100, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    check("R5 zero flag alone", 8'h04);
    pulse(4'b0001, 4'b1111, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    check("R5 carry flag alone", 8'h05);
    // write 1010, ALU strobes C and AC with zeros: C=0 AC=0 Z=0 OV=1
    pulse(4'b0011, 4'b0000, 1'b1, 4'b1010, 1'b0, 1'b0, 1'b0);
    check("R6 alu beats write", 8'h08);
  endtask

  task automatic t_system();
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    check("R9 expiry sets timeout", 8'h28);
    pulse(4'h0, 4'h0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
    check("R4 write keeps timeout", 8'h20);
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1);
    check("R7 halt", 8'h10);
    pulse(4'h0, 4'h0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0);
    check("R4 write keeps sleep", 8'h1F);
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    check("R9 expiry keeps sleep", 8'h3F);
    repeat (3) @(negedge clk);
    check("R11 hold", 8'h3F);
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
    check("R8 watchdog clear", 8'h0F);
  endtask

  task automatic t_collide();
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1);
    check("R10 expiry with halt", 8'h3F);
    pulse(4'h0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);
    check("R10 expiry with clear", 8'h2F);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R2 async clear", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 after release", 8'h00);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sw_write();
    t_alu();
    t_system();
    t_collide();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule